// File: doc/BRIEF.md
# Mode-Dependent Port Pin Multiplexer

This block runs one eight-pin general-purpose port. It has a stored output-data register and a direction register. It decides, pin by pin and cycle by cycle, whether each pin carries plain port I/O or one of the bus-control signals that the bus controller supplies. Ownership depends on the expanded-mode enable and on a set of per-pin override enables. The top pin is different. It follows its own direction bit in every mode and, when set to output, drives the system clock.

Software reaches the two registers through a small write/read interface. A select bit picks the register, a write strobe stores the write data on the next clock, and the read data shows the selected register at once. A hardware-standby input clears both registers. A software-standby input freezes them. Pin levels come back through a two-flop synchronizer, and the synchronized level of the wait pin is handed to the bus controller.

Top module: `port_pin_mux`

## Requirements
- R1: After the asynchronous reset, the data register and the direction register both read 0x00, so every pin has pin_oe low.
- R2: With reg_we high, the register chosen by reg_sel (0 = data, 1 = direction) takes reg_wdata at the next rising clock edge. reg_rdata always shows the selected register's stored value.
- R3: While hw_stby is high, both registers are cleared to 0x00 at each clock edge and register writes have no effect.
- R4: While sw_stby is high and hw_stby is low, both registers keep their contents and register writes have no effect.
- R5: A pin that no function claims drives pin_out from its data bit, and pin_oe equals its direction bit (1 = output).
- R6: Pin 7, in any mode: direction bit 1 gives pin_oe[7]=1 with pin_out[7]=clk_out_val. Direction bit 0 gives pin_oe[7]=0.
- R7: In expanded mode (exp_en=1) with as_oe=1, pin 6 drives as_val with pin_oe[6]=1.
- R8: In expanded mode, pins 5 and 4 always drive rd_val and hwr_val with pin_oe high, whatever their direction bits hold.
- R9: In expanded mode with lwr_oe=1, pin 3 drives lwr_val with pin_oe[3]=1.
- R10: In expanded mode, bus_fn_en[2] puts lcas_val on pin 2 and bus_fn_en[1] puts ucas_val on pin 1, each with pin_oe high. bus_fn_en[0] makes pin 0 the wait input: pin_oe[0]=0, and wait_sync carries the synchronized pin 0 level. wait_sync is 0 when that function is off.
- R11: With exp_en=0, pins 6 to 0 are plain I/O whatever as_oe, lwr_oe and bus_fn_en hold.
- R12: pin_rd equals pin_in as sampled two rising clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| hw_stby | input | 1 | Hardware standby: clears both registers |
| sw_stby | input | 1 | Software standby: freezes both registers |
| reg_sel | input | 1 | Register select, 0 data, 1 direction |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| exp_en | input | 1 | Expanded-mode enable |
| as_oe | input | 1 | Address-strobe output enable for pin 6 |
| lwr_oe | input | 1 | Low-byte write-strobe enable for pin 3 |
| bus_fn_en | input | 3 | Bus-function selects for pins 2, 1, 0 |
| clk_out_val | input | 1 | System clock value for pin 7 |
| as_val | input | 1 | Address strobe value |
| rd_val | input | 1 | Read strobe value |
| hwr_val | input | 1 | High-byte write strobe value |
| lwr_val | input | 1 | Low-byte write strobe value |
| lcas_val | input | 1 | Lower column strobe value |
| ucas_val | input | 1 | Upper column strobe value |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_rd | output | 8 | Synchronized pad levels |
| wait_sync | output | 1 | Synchronized wait level to the bus controller |

## Verification
A register write and a standby request can arrive in the same clock. The bench provokes this by raising reg_we together with hw_stby, and separately with sw_stby, for both register selects. It then reads back: hardware standby must leave 0x00, and software standby must leave the old contents. A second overlap puts a direction-register write to pin 0 in the same cycle as a wait-function select. The wait function must keep pin_oe[0] low, while the written bit becomes visible again once the select drops. A behavioural model compares every output on every clock through directed phases and a long random phase.

// File: rtl/port_mux_pkg.sv
package port_mux_pkg;
  localparam int unsigned PORT_W      = 8;
  localparam int unsigned SYNC_STAGES = 2;

  // Pin positions: the ownership logic decodes these
  localparam int unsigned PIN_CLK  = 7;
  localparam int unsigned PIN_AS   = 6;
  localparam int unsigned PIN_RD   = 5;
  localparam int unsigned PIN_HWR  = 4;
  localparam int unsigned PIN_LWR  = 3;
  localparam int unsigned PIN_LCAS = 2;
  localparam int unsigned PIN_UCAS = 1;
  localparam int unsigned PIN_WAIT = 0;

  typedef enum logic {SEL_DATA = 1'b0, SEL_DIR = 1'b1} reg_sel_e;

  typedef struct packed {
    logic clk_o;
    logic as_s;
    logic rd_s;
    logic hwr_s;
    logic lwr_s;
    logic lcas_s;
    logic ucas_s;
  } bus_drive_t;

  typedef struct packed {
    logic       exp_en;
    logic       as_en;
    logic       lwr_en;
    logic [2:0] fn_en;
  } own_ctl_t;
endpackage

// File: rtl/port_regs.sv
module port_regs
  import port_mux_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hw_stby,
  input  logic         sw_stby,
  input  logic         sel,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rdata
);
  logic [W-1:0] data_d, dir_d;
  logic         data_en, dir_en;

  // hardware standby outranks software standby, which outranks a write
  always_comb begin
    data_d  = wdata;
    dir_d   = wdata;
    data_en = 1'b0;
    dir_en  = 1'b0;
    if (hw_stby) begin
      data_d  = '0;
      dir_d   = '0;
      data_en = 1'b1;
      dir_en  = 1'b1;
    end else if (!sw_stby && we) begin
      data_en = (sel == SEL_DATA);
      dir_en  = (sel == SEL_DIR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (data_en) data_q <= data_d;
      if (dir_en)  dir_q  <= dir_d;
    end
  end

  assign rdata = (sel == SEL_DIR) ? dir_q : data_q;
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  assign chain_d[0] = d;
  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    assign chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pin_owner.sv
module pin_owner
  import port_mux_pkg::*;
(
  input  logic [PORT_W-1:0] data_q,
  input  logic [PORT_W-1:0] dir_q,
  input  own_ctl_t          ctl,
  input  bus_drive_t        drv,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic              wait_active
);
  always_comb begin
    pin_out = data_q;
    pin_oe  = dir_q;
    // top pin: clock out or input, in every mode
    if (dir_q[PIN_CLK]) pin_out[PIN_CLK] = drv.clk_o;
    if (ctl.exp_en) begin
      if (ctl.as_en) begin
        pin_out[PIN_AS] = drv.as_s;
        pin_oe[PIN_AS]  = 1'b1;
      end
      pin_out[PIN_RD]  = drv.rd_s;
      pin_oe[PIN_RD]   = 1'b1;
      pin_out[PIN_HWR] = drv.hwr_s;
      pin_oe[PIN_HWR]  = 1'b1;
      if (ctl.lwr_en) begin
        pin_out[PIN_LWR] = drv.lwr_s;
        pin_oe[PIN_LWR]  = 1'b1;
      end
      if (ctl.fn_en[2]) begin
        pin_out[PIN_LCAS] = drv.lcas_s;
        pin_oe[PIN_LCAS]  = 1'b1;
      end
      if (ctl.fn_en[1]) begin
        pin_out[PIN_UCAS] = drv.ucas_s;
        pin_oe[PIN_UCAS]  = 1'b1;
      end
      if (ctl.fn_en[0]) pin_oe[PIN_WAIT] = 1'b0;
    end
  end

  assign wait_active = ctl.exp_en & ctl.fn_en[0];
endmodule

// File: rtl/port_pin_mux.sv
module port_pin_mux
  import port_mux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_stby,
  input  logic       sw_stby,
  input  logic       reg_sel,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       exp_en,
  input  logic       as_oe,
  input  logic       lwr_oe,
  input  logic [2:0] bus_fn_en,
  input  logic       clk_out_val,
  input  logic       as_val,
  input  logic       rd_val,
  input  logic       hwr_val,
  input  logic       lwr_val,
  input  logic       lcas_val,
  input  logic       ucas_val,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  output logic [7:0] pin_rd,
  output logic       wait_sync
);
  logic [PORT_W-1:0] data_q, dir_q;
  logic              wait_active;
  own_ctl_t          ctl;
  bus_drive_t        drv;

  assign ctl = '{exp_en: exp_en, as_en: as_oe, lwr_en: lwr_oe, fn_en: bus_fn_en};
  assign drv = '{clk_o: clk_out_val, as_s: as_val, rd_s: rd_val, hwr_s: hwr_val,
                 lwr_s: lwr_val, lcas_s: lcas_val, ucas_s: ucas_val};

  port_regs #(.W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .sel(reg_sel), .we(reg_we), .wdata(reg_wdata),
    .data_q(data_q), .dir_q(dir_q), .rdata(reg_rdata)
  );

  pin_owner u_owner (
    .data_q(data_q), .dir_q(dir_q), .ctl(ctl), .drv(drv),
    .pin_out(pin_out), .pin_oe(pin_oe), .wait_active(wait_active)
  );

  pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_rd)
  );

  assign wait_sync = pin_rd[PIN_WAIT] & wait_active;
endmodule

// File: rtl/port_pin_mux_chk.sv
module port_pin_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_stby,
  input logic       sw_stby,
  input logic       exp_en,
  input logic [2:0] bus_fn_en,
  input logic       clk_out_val,
  input logic [7:0] data_q,
  input logic [7:0] dir_q,
  input logic [7:0] reg_rdata,
  input logic [7:0] pin_in,
  input logic [7:0] pin_out,
  input logic [7:0] pin_oe,
  input logic [7:0] pin_rd
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R3
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (reg_rdata == 8'h00));

  // R4
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> ($stable(data_q) && $stable(dir_q)));

  // R6
  clk_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q[7] |-> (pin_oe[7] && (pin_out[7] == clk_out_val)));

  // R8
  strobe_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_en |-> (pin_oe[5] && pin_oe[4]));

  // R10
  wait_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_en && bus_fn_en[0]) |-> !pin_oe[0]);

  // R11
  single_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exp_en |-> (pin_oe[6:0] == dir_q[6:0]));

  // R12
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (pin_rd == $past(pin_in, 2)));
endmodule

bind port_pin_mux port_pin_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
  .exp_en(exp_en), .bus_fn_en(bus_fn_en), .clk_out_val(clk_out_val),
  .data_q(data_q), .dir_q(dir_q), .reg_rdata(reg_rdata),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_rd(pin_rd)
);

// File: tb/test_port_pin_mux.sv
`timescale 1ns/1ps
module test_port_pin_mux;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hw_stby, sw_stby, reg_sel, reg_we;
  logic [7:0] reg_wdata, reg_rdata;
  logic       exp_en, as_oe, lwr_oe;
  logic [2:0] bus_fn_en;
  logic       clk_out_val, as_val, rd_val, hwr_val, lwr_val, lcas_val, ucas_val;
  logic [7:0] pin_in, pin_out, pin_oe, pin_rd;
  logic       wait_sync;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string req = "R1";

  always #2 clk = ~clk;

  port_pin_mux i_port_pin_mux (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .exp_en(exp_en), .as_oe(as_oe), .lwr_oe(lwr_oe), .bus_fn_en(bus_fn_en),
    .clk_out_val(clk_out_val), .as_val(as_val), .rd_val(rd_val), .hwr_val(hwr_val),
    .lwr_val(lwr_val), .lcas_val(lcas_val), .ucas_val(ucas_val),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_rd(pin_rd),
    .wait_sync(wait_sync)
  );

  // behavioural reference state
  logic [7:0] m_data, m_dir;
  logic [7:0] m_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 8'h00;
      m_dir  = 8'h00;
      m_hist = '{8'h00, 8'h00};
    end else begin
      if (hw_stby) begin
        m_data = 8'h00;
        m_dir  = 8'h00;
      end else if (!sw_stby && reg_we) begin
        if (reg_sel) m_dir = reg_wdata;
        else         m_data = reg_wdata;
      end
      m_hist.push_back(pin_in);
      void'(m_hist.pop_front());
    end
  end

  task automatic expect_bits(string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e_out, e_oe, e_rd;
    logic       e_wait;
    e_out = m_data;
    e_oe  = m_dir;
    if (m_dir[7]) e_out[7] = clk_out_val;
    if (exp_en) begin
      if (as_oe) begin e_out[6] = as_val; e_oe[6] = 1'b1; end
      e_out[5] = rd_val;  e_oe[5] = 1'b1;
      e_out[4] = hwr_val; e_oe[4] = 1'b1;
      if (lwr_oe) begin e_out[3] = lwr_val; e_oe[3] = 1'b1; end
      if (bus_fn_en[2]) begin e_out[2] = lcas_val; e_oe[2] = 1'b1; end
      if (bus_fn_en[1]) begin e_out[1] = ucas_val; e_oe[1] = 1'b1; end
      if (bus_fn_en[0]) e_oe[0] = 1'b0;
    end
    e_rd   = m_hist[0];
    e_wait = exp_en && bus_fn_en[0] && e_rd[0];
    expect_bits("pin_out", pin_out, e_out);
    expect_bits("pin_oe", pin_oe, e_oe);
    expect_bits("pin_rd", pin_rd, e_rd);
    expect_bits("wait_sync", {7'b0, wait_sync}, {7'b0, e_wait});
    expect_bits("reg_rdata", reg_rdata, reg_sel ? m_dir : m_data);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic sel, logic [7:0] v);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = v;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd_check(logic sel, logic [7:0] exp);
    reg_sel = sel;
    #0.1;
    expect_bits(sel ? "dir readback" : "data readback", reg_rdata, exp);
  endtask

  initial begin
    rst_n = 1'b0; hw_stby = 0; sw_stby = 0; reg_sel = 0; reg_we = 0; reg_wdata = 0;
    exp_en = 0; as_oe = 0; lwr_oe = 0; bus_fn_en = 0; clk_out_val = 0;
    as_val = 0; rd_val = 0; hwr_val = 0; lwr_val = 0; lcas_val = 0; ucas_val = 0;
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    req = "R1";
    tick();
    rd_check(1'b0, 8'h00);
    rd_check(1'b1, 8'h00);
    expect_bits("reset pin_oe", pin_oe, 8'h00);

    // R2 register write/read
    req = "R2";
    wr(1'b0, 8'hA5);
    wr(1'b1, 8'h3C);
    tick();
    rd_check(1'b0, 8'hA5);
    rd_check(1'b1, 8'h3C);

    // R5 plain I/O in single-chip mode
    req = "R5";
    tick();
    expect_bits("plain oe", pin_oe, 8'h3C);
    expect_bits("plain out", pin_out, 8'hA5);

    // R6 clock pin
    req = "R6";
    wr(1'b1, 8'hBC);
    clk_out_val = 1'b1; tick();
    clk_out_val = 1'b0; tick();
    exp_en = 1'b1; clk_out_val = 1'b1; tick();
    wr(1'b1, 8'h3C); tick();
    exp_en = 1'b0;

    // R11 single-chip ignores every enable
    req = "R11";
    as_oe = 1; lwr_oe = 1; bus_fn_en = 3'b111;
    as_val = 1; rd_val = 1; hwr_val = 1; lwr_val = 1; lcas_val = 1; ucas_val = 1;
    tick();
    expect_bits("single-chip oe", pin_oe, 8'h3C);

    // R7 R9 R10 expanded-mode overrides, R8 forced strobes
    exp_en = 1; as_oe = 0; lwr_oe = 0; bus_fn_en = 3'b000;
    req = "R8"; wr(1'b1, 8'h00); tick();
    expect_bits("forced strobe oe", pin_oe, 8'h30);
    req = "R7"; as_oe = 1; tick(); as_val = 0; tick();
    req = "R9"; lwr_oe = 1; tick(); lwr_val = 0; tick();
    req = "R10";
    bus_fn_en = 3'b100; tick();
    bus_fn_en = 3'b010; tick();
    pin_in = 8'h01; bus_fn_en = 3'b001;
    wr(1'b1, 8'h01);            // write dir bit0 alongside wait select
    tick(); tick();
    expect_bits("wait level", {7'b0, wait_sync}, 8'h01);
    expect_bits("wait oe0", {7'b0, pin_oe[0]}, 8'h00);
    bus_fn_en = 3'b000; tick();
    expect_bits("dir bit back", {7'b0, pin_oe[0]}, 8'h01);

    // R12 synchronizer delay
    req = "R12";
    for (int i = 0; i < 12; i++) begin
      pin_in = 8'(i * 37 + 5);
      tick();
    end

    // R4 software standby freezes registers
    req = "R4";
    exp_en = 0;
    wr(1'b0, 8'h5A); wr(1'b1, 8'hC3);
    sw_stby = 1;
    wr(1'b0, 8'hFF); wr(1'b1, 8'h00);
    rd_check(1'b0, 8'h5A);
    rd_check(1'b1, 8'hC3);
    sw_stby = 0; tick();

    // R3 hardware standby clears and blocks writes
    req = "R3";
    hw_stby = 1;
    wr(1'b0, 8'h77); wr(1'b1, 8'h77);
    rd_check(1'b0, 8'h00);
    rd_check(1'b1, 8'h00);
    hw_stby = 0; tick();

    // random mix, compared every cycle
    req = "R5";
    for (int i = 0; i < 600; i++) begin
      hw_stby   = ($urandom_range(0, 19) == 0);
      sw_stby   = ($urandom_range(0, 9) == 0);
      reg_sel   = 1'($urandom);
      reg_we    = 1'($urandom);
      reg_wdata = 8'($urandom);
      exp_en    = 1'($urandom);
      as_oe     = 1'($urandom);
      lwr_oe    = 1'($urandom);
      bus_fn_en = 3'($urandom);
      {clk_out_val, as_val, rd_val, hwr_val, lwr_val, lcas_val, ucas_val} = 7'($urandom);
      pin_in    = 8'($urandom);
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule